// File: doc/BRIEF.md
# I2S Bus Master Transmitter and Receiver

This block drives a stereo serial audio link as the bus master. From a master clock that runs at one of three fixed rates, it makes the bit clock and the word strobe, so that one left/right frame lasts exactly 1/48000 s. It sends each output sample MSB first on the serial data output. In the same frame slots it collects the data that an external device shifts in on the serial data input. That device runs in step with the generated clocks, so its data is sampled without a synchroniser.

A client hands over the next stereo pair through a ready/valid handshake. A pair given at any point in a frame goes out in full from the next frame start. If no pair arrives, the last pair is sent again. Each received pair appears on parallel outputs with a one-cycle valid pulse. Words are 16 or 32 bits. The word strobe can lead the MSB by one bit clock (standard framing) or line up with it, and its level can be inverted. The settings are expected to change only while reset is held.

Top module: `i2s_master`

## Requirements
- R1: The bit clock is low in reset. Each of its high and low phases lasts H master-clock cycles. With 32-bit words, H is 3, 4 or 6 for `mclk_sel` = 0, 1, 2 (18.432, 24.576, 36.864 MHz). With 16-bit words, H is 6, 8 or 12.
- R2: One frame (two words) lasts 384, 512 or 768 master-clock cycles for `mclk_sel` = 0, 1, 2. This is a 48 kHz frame rate for both word lengths.
- R3: The word strobe is 0 during the left word and 1 during the right word when `ws_invert`=0, and is inverted when `ws_invert`=1. It changes level every W bit clocks, where W is 32 when `word32`=1 and 16 otherwise.
- R4: Each word is sent MSB first, left word then right word. With `std_delay`=1 the MSB is in the bit period after the strobe edge. With `std_delay`=0 it is in the same bit period. With 16-bit words only bits 15:0 of the supplied samples are sent.
- R5: `sd_out` and `ws` change only on a master-clock edge at which the bit clock falls.
- R6: `sd_in` is sampled at each rising bit-clock edge. After the last right-word bit, `rx_left`/`rx_right` carry the frame's two words (zero-extended in 16-bit mode) and `rx_valid` pulses high for exactly one cycle.
- R7: `tx_ready` is high in reset and whenever the one-entry pending slot is empty. A pair is taken when `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until that pair starts transmission at the next left-word MSB.
- R8: If no new pair has been taken before a frame starts, the previous pair is sent again.
- R9: In reset `sd_out`=0, `rx_valid`=0 and `ws` equals `ws_invert`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclk_sel | input | 2 | Master clock rate: 0=18.432, 1=24.576, 2=36.864 MHz |
| word32 | input | 1 | 1 selects 32-bit words, 0 selects 16-bit words |
| std_delay | input | 1 | 1 puts the MSB one bit after the strobe edge |
| ws_invert | input | 1 | Inverts the word strobe level |
| tx_left | input | 32 | Left sample to send |
| tx_right | input | 32 | Right sample to send |
| tx_valid | input | 1 | Output pair offered |
| tx_ready | output | 1 | Pending slot is free |
| bclk | output | 1 | Generated bit clock |
| ws | output | 1 | Generated word strobe |
| sd_out | output | 1 | Serial data to the external device |
| sd_in | input | 1 | Serial data from the external device |
| rx_left | output | 32 | Last received left word |
| rx_right | output | 32 | Last received right word |
| rx_valid | output | 1 | One-cycle pulse when a received pair is updated |

## Verification
A wrong divisor or slot count shows up within one bit period as a bit-clock phase of the wrong length, and within one frame as a strobe period other than 384/512/768 cycles. A bad slot-to-bit mapping or a wrong delay offset shows up in the first complete frame after a pair is loaded, as a shifted or reordered word on `sd_out`. Because `sd_out` is looped back to `sd_in`, the same fault appears in `rx_left`/`rx_right` at the end of that frame. A lost or stuck pending slot appears in `tx_ready` one cycle after a handshake, or as the old pair repeating in the frame after a new pair was offered.

// File: rtl/i2s_master.sv
module i2s_master (
  input  logic        mclk,
  input  logic        rst_n,
  input  logic [1:0]  mclk_sel,
  input  logic        word32,
  input  logic        std_delay,
  input  logic        ws_invert,
  input  logic [31:0] tx_left,
  input  logic [31:0] tx_right,
  input  logic        tx_valid,
  output logic        tx_ready,
  output logic        bclk,
  output logic        ws,
  output logic        sd_out,
  input  logic        sd_in,
  output logic [31:0] rx_left,
  output logic [31:0] rx_right,
  output logic        rx_valid
);

  logic [3:0]  half, hcnt;
  logic [6:0]  wlen, last, slot, slot_n, pos_c, pos_n, bidx;
  logic        tick, fall, rise, ch;
  logic [31:0] cur_l, cur_r, pend_l, pend_r, acc_l, acc_r;
  logic        pend_full;

  always_comb begin
    case (mclk_sel)
      2'd0:    half = word32 ? 4'd3 : 4'd6;
      2'd1:    half = word32 ? 4'd4 : 4'd8;
      default: half = word32 ? 4'd6 : 4'd12;
    endcase
  end

  function automatic logic [6:0] pos_of(input logic [6:0] s, input logic dly, input logic [6:0] lst);
    pos_of = dly ? ((s == 7'd0) ? lst : s - 7'd1) : s;
  endfunction

  function automatic logic [31:0] fit(input logic [31:0] x, input logic w32);
    fit = w32 ? x : {16'h0000, x[15:0]};
  endfunction

  assign wlen   = word32 ? 7'd32 : 7'd16;
  assign last   = (wlen << 1) - 7'd1;
  assign tick   = (hcnt == half - 4'd1);
  assign fall   = tick & bclk;
  assign rise   = tick & ~bclk;
  assign slot_n = (slot >= last) ? 7'd0 : slot + 7'd1;
  assign pos_c  = pos_of(slot, std_delay, last);
  assign pos_n  = pos_of(slot_n, std_delay, last);
  assign ch     = (pos_c >= wlen);
  assign bidx   = (ch ? last : wlen - 7'd1) - pos_c;

  assign sd_out   = ch ? cur_r[bidx[4:0]] : cur_l[bidx[4:0]];
  assign ws       = (slot >= wlen) ^ ws_invert;
  assign tx_ready = ~pend_full;

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      hcnt      <= '0;
      bclk      <= 1'b0;
      slot      <= '0;
      cur_l     <= '0;
      cur_r     <= '0;
      pend_l    <= '0;
      pend_r    <= '0;
      pend_full <= 1'b0;
    end else begin
      hcnt <= tick ? 4'd0 : hcnt + 4'd1;
      if (tick) bclk <= ~bclk;
      if (fall) begin
        slot <= slot_n;
        if (pos_n == 7'd0 && pend_full) begin
          cur_l     <= pend_l;
          cur_r     <= pend_r;
          pend_full <= 1'b0;
        end
      end
      if (tx_valid && !pend_full) begin
        pend_l    <= tx_left;
        pend_r    <= tx_right;
        pend_full <= 1'b1;
      end
    end
  end

  always_ff @(posedge mclk) begin
    if (!rst_n) begin
      acc_l    <= '0;
      acc_r    <= '0;
      rx_left  <= '0;
      rx_right <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise) begin
        if (ch) acc_r <= {acc_r[30:0], sd_in};
        else    acc_l <= {acc_l[30:0], sd_in};
        if (pos_c == last) begin
          rx_left  <= fit(acc_l, word32);
          rx_right <= fit({acc_r[30:0], sd_in}, word32);
          rx_valid <= 1'b1;
        end
      end
    end
  end

  a_r5_ws_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$fell(bclk) |-> $stable(ws));
  a_r5_sd_on_fall: assert property (@(posedge mclk) disable iff (!rst_n)
    !$fell(bclk) |-> $stable(sd_out));
  a_r6_valid_pulse: assert property (@(posedge mclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r6_valid_on_rise: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(rx_valid) |-> $rose(bclk));
  a_r7_take_blocks: assert property (@(posedge mclk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

endmodule

// File: tb/test_i2s_master.sv
`timescale 1ns/1ps
module test_i2s_master;
  logic        mclk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mclk_sel = 2'd0;
  logic        word32 = 1'b1, std_delay = 1'b1, ws_invert = 1'b0;
  logic [31:0] tx_left = '0, tx_right = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, bclk, ws, sd_out, sd_in, rx_valid;
  logic [31:0] rx_left, rx_right;

  int total = 0, bad = 0;
  bit done = 0;
  logic cws [0:255];
  logic csd [0:255];

  always #2 mclk = ~mclk;
  assign sd_in = sd_out;

  i2s_master i_i2s_master (
    .mclk(mclk), .rst_n(rst_n), .mclk_sel(mclk_sel), .word32(word32),
    .std_delay(std_delay), .ws_invert(ws_invert), .tx_left(tx_left),
    .tx_right(tx_right), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .bclk(bclk), .ws(ws), .sd_out(sd_out), .sd_in(sd_in),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  // {sel, word32, delay, invert, half, frame}
  localparam logic [18:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b1, 1'b0, 4'd3,  10'd384},
    {2'd1, 1'b1, 1'b0, 1'b1, 4'd4,  10'd512},
    {2'd2, 1'b1, 1'b1, 1'b1, 4'd6,  10'd768},
    {2'd0, 1'b0, 1'b0, 1'b0, 4'd6,  10'd384},
    {2'd1, 1'b0, 1'b1, 1'b0, 4'd8,  10'd512},
    {2'd2, 1'b0, 1'b0, 1'b1, 4'd12, 10'd768}};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_rise(output int n);
    logic p;
    p = bclk;
    n = 0;
    forever begin
      @(negedge mclk);
      n++;
      if (!p && bclk) break;
      p = bclk;
    end
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge mclk);
    chk(tx_ready === 1'b1, "R7 ready before offer", {31'b0, tx_ready}, 32'd1);
    tx_left = l; tx_right = r; tx_valid = 1'b1;
    @(negedge mclk);
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, "R7 ready low after take", {31'b0, tx_ready}, 32'd0);
  endtask

  task automatic capture_check(input logic [31:0] el, input logic [31:0] er, input int w,
                               input logic dly, input logic inv, input string tag);
    int n, st, ms;
    bit ok;
    logic [31:0] gl, gr;
    st = -1;
    for (int k = 0; k < 8*w; k++) begin
      wait_rise(n);
      cws[k] = ws; csd[k] = sd_out;
    end
    for (int k = 2*w; k < 4*w; k++)
      if (st < 0 && cws[k] == inv && cws[k-1] != inv) st = k;
    chk(st >= 0, {"R3 left strobe edge found ", tag}, st, 32'd0);
    if (st < 0) return;
    ok = 1;
    for (int k = 0; k < 2*w; k++)
      if (cws[st+k] != ((k < w) ? inv : ~inv)) ok = 0;
    chk(ok, {"R3 strobe level per word ", tag}, {31'b0, ok}, 32'd1);
    ms = st + int'(dly);
    for (int f = 0; f < 2; f++) begin
      gl = '0; gr = '0;
      for (int k = 0; k < w; k++) begin
        gl = {gl[30:0], csd[ms + f*2*w + k]};
        gr = {gr[30:0], csd[ms + f*2*w + w + k]};
      end
      chk(gl === el, f == 0 ? {"R4 left word ", tag} : {"R8 repeated left ", tag}, gl, el);
      chk(gr === er, f == 0 ? {"R4 right word ", tag} : {"R8 repeated right ", tag}, gr, er);
    end
    chk(rx_left === el, {"R6 received left ", tag}, rx_left, el);
    chk(rx_right === er, {"R6 received right ", tag}, rx_right, er);
  endtask

  initial begin
    repeat (150000) @(posedge mclk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, cnt;
    logic [31:0] al, ar, bl, br, m;
    for (int v = 0; v < 6; v++) begin
      logic [18:0] e;
      int w;
      e = VEC[v];
      mclk_sel = e[18:17]; word32 = e[16]; std_delay = e[15]; ws_invert = e[14];
      w = word32 ? 32 : 16;
      m = word32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
      al = 32'hC3A5_9E17 ^ (v * 32'h0101_0101);
      ar = 32'h5B2D_E681 + (v * 32'h0011_2233);
      bl = ~al;
      br = {ar[15:0], ar[31:16]};

      rst_n = 1'b0;
      repeat (4) @(negedge mclk);
      chk(bclk === 1'b0, "R1 bit clock low in reset", {31'b0, bclk}, 32'd0);
      chk(ws === ws_invert, "R9 strobe level in reset", {31'b0, ws}, {31'b0, ws_invert});
      chk(sd_out === 1'b0 && rx_valid === 1'b0, "R9 data and valid low in reset",
          {30'b0, sd_out, rx_valid}, 32'd0);
      chk(tx_ready === 1'b1, "R7 ready in reset", {31'b0, tx_ready}, 32'd1);
      rst_n = 1'b1;

      push(al, ar);
      wait_rise(n);
      wait_rise(n);
      chk(n == 2 * int'(e[13:10]), "R1 bit clock period", n, 2 * e[13:10]);

      cnt = 0;
      begin
        logic p;
        p = ws;
        forever begin @(negedge mclk); if (!p && ws) break; p = ws; end
        p = ws;
        forever begin @(negedge mclk); cnt++; if (!p && ws) break; p = ws; end
      end
      chk(cnt == int'(e[9:0]), "R2 frame length", cnt, {22'b0, e[9:0]});

      capture_check(al & m, ar & m, w, std_delay, ws_invert, "first pair");
      push(bl, br);
      capture_check(bl & m, br & m, w, std_delay, ws_invert, "second pair");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule